// File: doc/BRIEF.md
# PHY Configuration Register Bridge

This block gives a host processor access to the 16-bit configuration registers inside a serial transceiver PHY through a single 32-bit control word. One host write carries the operation (read or write), the PHY register address and, for a write, the data. The bridge raises a busy flag and presents the request on the PHY register port. It holds the request until the PHY acknowledges, which may take any number of cycles. It then clears busy. For a read, it places the returned data in the upper half of the same word.

Software starts an operation and then polls the word until busy drops. The data field is loaded on the same clock edge that clears busy, so a poll that sees busy low also sees the final data. A write that arrives while an operation is running is dropped, and a sticky collision flag records it. A cycle limit ends an operation that the PHY never acknowledges, clears busy and sets a timeout flag. This keeps every poll loop bounded.

Top module: `phy_reg_bridge`

## Requirements
- R1: A host write (host_valid=1, host_we=1) while busy is 0 is accepted on that clock edge. From the next cycle on, busy (word bit 7) reads 1, phy_req is 1, phy_we equals written bit 0 (1 = PHY write, 0 = PHY read) and phy_addr equals written bits 15:8.
- R2: During a PHY write, phy_wdata equals the written bits 31:16 for as long as phy_req is high.
- R3: phy_req stays high until the first clock edge at which phy_ack is 1. That edge clears busy and phy_req. An acknowledge after L waiting cycles gives exactly L+1 busy cycles.
- R4: When a read completes, word bits 31:16 take phy_rdata on the same edge that clears busy.
- R5: When a write completes, word bits 31:16 keep the data that was written.
- R6: A host write while busy is 1 changes neither the operation, the address nor the data. It sets the collision flag (word bit 1), which stays set until the next accepted host write clears it.
- R7: If no acknowledge arrives, the operation ends after exactly TIMEOUT_CYCLES busy cycles. busy and phy_req clear, the timeout flag (word bit 2) is set and bits 31:16 are unchanged. An acknowledge in the last allowed cycle completes normally, with no timeout. An accepted host write clears the timeout flag.
- R8: Synchronous active-low reset, including a reset during an operation, makes the word all zeros and phy_req 0.
- R9: host_rdata always shows the word: bit 0 operation, bit 1 collision, bit 2 timeout, bits 6:3 zero, bit 7 busy, bits 15:8 address, bits 31:16 data. Written bits 7:1 are ignored. host_ready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access strobe |
| host_we | input | 1 | Host access is a write of the control word |
| host_wdata | input | 32 | Control word written by the host |
| host_ready | output | 1 | Access accepted (always 1) |
| host_rdata | output | 32 | Current control/status/data word |
| phy_req | output | 1 | PHY register request, held until acknowledge |
| phy_we | output | 1 | 1 = PHY register write, 0 = read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 16 | PHY register write data |
| phy_ack | input | 1 | PHY acknowledge, one cycle |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack |

## Verification
An accepted command shows busy and the PHY request one cycle after the accepting edge. Completion lands on the edge that samples the acknowledge, so an acknowledge after L waiting cycles gives exactly L+1 busy cycles, and a silent PHY gives exactly TIMEOUT_CYCLES. The bench drives and samples on the falling edge, counts busy cycles between acceptance and the first idle sample, and compares that count and the final word with values derived from the latency it programmed into its PHY responder. Collision and reset effects are checked one falling edge after the edge that registers them.

// File: rtl/phyb_pkg.sv
// Package: shared layout of the bridge control word and PHY port widths.
// Assumes a 32-bit host word and a 16-bit PHY register file.
package phyb_pkg;
    localparam int PHY_AW = 8;
    localparam int PHY_DW = 16;
    localparam int WORD_W = 32;

    // Control word, MSB first: data, address, busy, zeros, timeout, collision, op
    typedef struct packed {
        logic [PHY_DW-1:0] data;
        logic [PHY_AW-1:0] addr;
        logic              busy;
        logic [3:0]        zero;
        logic              err_tmo;
        logic              err_col;
        logic              op_wr;
    } ctrl_word_t;
endpackage

// File: rtl/phyb_timeout.sv
// Module: counts cycles of an outstanding PHY operation and flags expiry.
// Assumes busy is the bridge's own busy flag; the count restarts whenever idle.
module phyb_timeout #(
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic ack,
    output logic expire
);
    localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Busy-cycle counter, cleared while idle or in reset
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // Expiry only when the window is used up and no acknowledge is present
    assign expire = busy && !ack && (cnt == LAST);

    p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (cnt == '0));
endmodule

// File: rtl/phyb_cmd_reg.sv
// Module: holds the combined command/status/data word and its busy flag.
// Assumes one operation at a time; completion, timeout and collision are
// resolved here with acknowledge winning over timeout.
module phyb_cmd_reg
    import phyb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              phy_ack,
    input  logic [PHY_DW-1:0] phy_rdata,
    input  logic              expire,
    output ctrl_word_t        word
);
    ctrl_word_t w_in;
    logic accept, collide, done;

    assign w_in    = ctrl_word_t'(host_wdata);
    assign accept  = host_valid && host_we && !word.busy;
    assign collide = host_valid && host_we && word.busy;
    assign done    = word.busy && phy_ack;

    // Bits the host may not set: hardware owns busy, flags and zeros
    logic unused_wbits;
    assign unused_wbits = ^{w_in.busy, w_in.zero, w_in.err_tmo, w_in.err_col};

    // Word update: start, completion, timeout, collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (accept) begin
            word.op_wr   <= w_in.op_wr;
            word.addr    <= w_in.addr;
            word.data    <= w_in.data;
            word.busy    <= 1'b1;
            word.err_col <= 1'b0;
            word.err_tmo <= 1'b0;
        end else begin
            if (done) begin
                word.busy <= 1'b0;
                if (!word.op_wr) word.data <= phy_rdata;
            end else if (expire) begin
                word.busy    <= 1'b0;
                word.err_tmo <= 1'b1;
            end
            if (collide) word.err_col <= 1'b1;
        end
    end

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!word.busy && host_valid && host_we) |=>
            (word.busy && word.addr == $past(host_wdata[15:8])));
    p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word.busy && phy_ack) |=> !word.busy);
    p_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word.busy && phy_ack && !word.op_wr) |=> (word.data == $past(phy_rdata)));
    p_wdata_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word.busy && phy_ack && word.op_wr) |=> $stable(word.data));
    p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word.busy && host_valid && host_we) |=>
            (word.err_col && $stable(word.addr) && $stable(word.op_wr)));
    p_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !host_valid) |=> (!word.busy && word.err_tmo && $stable(word.data)));
    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word.zero == 4'b0);
endmodule

// File: rtl/phy_reg_bridge.sv
// Module: top of the PHY configuration register bridge. A host write of the
// control word starts one PHY register operation; the word reports busy,
// sticky errors and read data. Assumes the PHY answers with a one-cycle ack.
module phy_reg_bridge
    import phyb_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [WORD_W-1:0] host_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [PHY_DW-1:0] phy_rdata
);
    ctrl_word_t word;
    logic       expire;

    phyb_cmd_reg u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .phy_ack    (phy_ack),
        .phy_rdata  (phy_rdata),
        .expire     (expire),
        .word       (word)
    );

    phyb_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (word.busy),
        .ack    (phy_ack),
        .expire (expire)
    );

    // Host side: single register, always ready, word shown directly
    assign host_ready = 1'b1;
    assign host_rdata = word;

    // PHY side: request is the busy flag; fields come from the word
    assign phy_req   = word.busy;
    assign phy_we    = word.op_wr;
    assign phy_addr  = word.addr;
    assign phy_wdata = word.data;

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack && !expire) |=> (phy_req && $stable(phy_addr) && $stable(phy_we)));
    p_wdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we && !phy_ack && !expire) |=> $stable(phy_wdata));
endmodule

// File: tb/tb_phy_reg_bridge.sv
// Bench: vector table walked by one loop, then directed corner tests.
module tb_phy_reg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [15:0] wd;
        logic [7:0]  lat;
        logic [15:0] resp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h09, 16'h5555, 8'd0, 16'h1234},
        '{1'b1, 8'h20, 16'hA5C3, 8'd2, 16'h0BAD},
        '{1'b0, 8'h30, 16'h5555, 8'd7, 16'hBEEF},
        '{1'b1, 8'h00, 16'h0000, 8'd1, 16'hFFFF},
        '{1'b0, 8'h1F, 16'h0000, 8'd3, 16'hFFFF},
        '{1'b1, 8'h2F, 16'h8001, 8'd0, 16'h7777}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        phy_req, phy_we;
    logic [7:0]  phy_addr;
    logic [15:0] phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;

    int checks = 0, fails = 0;
    int resp_lat = 0;
    logic [15:0] resp_val = '0;
    logic mute = 1'b0;
    logic cap_we = 1'b0;
    logic [7:0] cap_addr = '0;
    logic [15:0] cap_wdata = '0;

    phy_reg_bridge #(.TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_we(host_we),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // PHY responder: acks after resp_lat waiting cycles, capturing the request
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            phy_ack = 1'b0;
            if (rst_n && phy_req && !mute) begin
                if (wcnt == resp_lat) begin
                    phy_ack = 1'b1;
                    phy_rdata = resp_val;
                    cap_we = phy_we;
                    cap_addr = phy_addr;
                    cap_wdata = phy_wdata;
                    wcnt = 0;
                end else wcnt++;
            end else wcnt = 0;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic start_cmd(input logic [31:0] w);
        @(negedge clk);
        host_valid = 1'b1; host_we = 1'b1; host_wdata = w;
        @(negedge clk);
        host_valid = 1'b0; host_we = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (host_rdata[7] && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        int cyc;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        check(host_rdata == 32'h0, "R8 reset word", host_rdata, 32'h0);
        check(phy_req == 1'b0, "R8 reset req", {31'b0, phy_req}, 32'h0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            resp_lat = int'(VECS[i].lat);
            resp_val = VECS[i].resp;
            w = {VECS[i].wd, VECS[i].addr, VECS[i].we ? 8'hFF : 8'hFE};
            start_cmd(w);
            check(host_rdata[7] && phy_req, "R1 busy and req", {host_rdata[7], phy_req}, 2'b11);
            check(phy_addr == VECS[i].addr && phy_we == VECS[i].we, "R1 addr/op",
                  {phy_we, phy_addr}, {VECS[i].we, VECS[i].addr});
            wait_idle(cyc);
            check(cyc == resp_lat + 1, "R3 busy cycles", cyc, resp_lat + 1);
            check(phy_req == 1'b0, "R3 req dropped", {31'b0, phy_req}, 32'h0);
            check(cap_addr == VECS[i].addr && cap_we == VECS[i].we, "R3 req at ack",
                  {cap_we, cap_addr}, {VECS[i].we, VECS[i].addr});
            if (VECS[i].we) begin
                check(cap_wdata == VECS[i].wd, "R2 phy_wdata", cap_wdata, VECS[i].wd);
                check(host_rdata[31:16] == VECS[i].wd, "R5 data kept",
                      host_rdata[31:16], VECS[i].wd);
            end else begin
                check(host_rdata[31:16] == VECS[i].resp, "R4 read data",
                      host_rdata[31:16], VECS[i].resp);
            end
            check(host_rdata[6:1] == 6'b0 && host_rdata[0] == VECS[i].we, "R9 low bits",
                  host_rdata[7:0], {7'b0, VECS[i].we});
        end
        check(host_ready == 1'b1, "R9 host_ready", {31'b0, host_ready}, 32'h1);

        // Collision: write while busy is dropped and flagged
        resp_lat = 5; resp_val = 16'h2468;
        start_cmd({16'h0000, 8'h0B, 8'h00});
        start_cmd({16'h9999, 8'h0D, 8'h01});
        check(host_rdata[15:8] == 8'h0B && host_rdata[0] == 1'b0, "R6 addr/op unchanged",
              host_rdata[15:0], 16'h0B00);
        check(host_rdata[1] == 1'b1, "R6 collision set", host_rdata[7:0], 8'h82);
        wait_idle(cyc);
        check(host_rdata[31:16] == 16'h2468, "R6 read completes", host_rdata[31:16], 16'h2468);
        check(host_rdata[1] == 1'b1, "R6 collision sticky", host_rdata[7:0], 8'h02);
        resp_lat = 0;
        start_cmd({16'h1111, 8'h01, 8'h01});
        check(host_rdata[1] == 1'b0, "R6 collision cleared", host_rdata[7:0], 8'h81);
        wait_idle(cyc);

        // Timeout on a silent PHY
        mute = 1'b1;
        start_cmd({16'h4444, 8'h21, 8'h01});
        wait_idle(cyc);
        check(cyc == TMO, "R7 timeout cycles", cyc, TMO);
        check(host_rdata[2] == 1'b1 && phy_req == 1'b0, "R7 timeout flag",
              {host_rdata[7:0], phy_req}, 9'h00A);
        check(host_rdata[31:16] == 16'h4444, "R7 data unchanged", host_rdata[31:16], 16'h4444);

        // Ack in the last allowed cycle wins
        mute = 1'b0; resp_lat = TMO - 1; resp_val = 16'hCAFE;
        start_cmd({16'h0000, 8'h22, 8'h00});
        check(host_rdata[2] == 1'b0, "R7 timeout flag cleared", host_rdata[7:0], 8'h80);
        wait_idle(cyc);
        check(cyc == TMO && host_rdata[2] == 1'b0, "R7 last-cycle ack",
              {cyc[15:0], 8'h0, host_rdata[7:0]}, {16'(TMO), 8'h0, 8'h00});
        check(host_rdata[31:16] == 16'hCAFE, "R4 last-cycle data", host_rdata[31:16], 16'hCAFE);

        // Reset during an operation
        mute = 1'b1;
        start_cmd({16'h7777, 8'h10, 8'h01});
        rst_n = 1'b0;
        @(negedge clk);
        check(host_rdata == 32'h0 && phy_req == 1'b0, "R8 reset mid-op",
              host_rdata, 32'h0);
        rst_n = 1'b1; mute = 1'b0;
        @(negedge clk);

        finish_run();
    end
endmodule